// File: doc/BRIEF.md
# Flash program/erase control unit

This block sits between a CPU and an on-chip flash program memory. A small register port lets software set the control bits and read the status bits. A CPU store to a flash word address is turned into one of three operations: word programming, erasing an aligned page, or erasing a whole block. The control register selects which one. A sequencer runs each operation for a fixed number of cycles against a behavioural flash array that lives inside the block. It can check the result afterwards and records program and erase failures in sticky status flags.

A one-word write buffer lets software queue the next store while an operation is still running. A store that arrives while the buffer is occupied is held off with a wait signal. When the buffer hands its word to the sequencer, an optional interrupt pulse tells software that the next word may be written. The memory holds `MAIN_BLOCKS` main blocks of `MAIN_WORDS` words each, placed from address 0 upward. An information block of `INFO_WORDS` words follows them and is paired with main block 0. With the defaults, main block 0 is words 0–63, main block 1 is words 64–127 and the information block is words 128–135.

Top module: `flash_pe_ctrl`

## Requirements
- R1: After reset the control register, the status register and the interrupt output all read zero, and every array word reads all ones.
- R2: The control register (reg_sel=0) holds these bits: 0 CPU lockout, 1 verify-off, 2 interrupt enable, 3 program mode, 4 page-erase mode, 5 block-erase mode. Bits 7:6 read zero. The status register (reg_sel=1) holds these bits: 0 erase error, 1 program error, 2 busy, 3 buffer full, 4 the level of the `dflash_err` input. Bits 7:5 read zero.
- R3: A control write that sets more than one of bits 3–5 leaves all three mode bits unchanged. The other bits of that write still take effect.
- R4: While busy, control writes leave bits 0, 1, 3, 4 and 5 unchanged. Bit 2 can still be written.
- R5: In program mode, an accepted store replaces the addressed word with the old value ANDed with the store data. Busy rises in the cycle after acceptance and stays high for exactly `PROG_CYC` (8) cycles.
- R6: A store is ignored if the CPU lockout bit is 1, if no mode bit is set, or if the address is at or above the array size (136). An ignored store starts nothing and changes no word.
- R7: In page-erase mode, a store sets every word of the aligned group of `PAGE_WORDS` (8) words that holds the address to all ones. Busy lasts `PAGE_CYC` (32) cycles, and words outside the group are unchanged.
- R8: In block-erase mode, a store to a main-block word sets that whole main block to all ones. A store to an information-block word erases the information block and main block 0. Busy lasts `MOD_CYC` (128) cycles, and other blocks are unchanged.
- R9: With verify-off at 0, a programmed word that does not read back as old AND data sets the program-error flag. With verify-off at 1, no check is made and the flag is not set.
- R10: An erase that leaves any targeted word other than all ones sets the erase-error flag. The `inj_stuck` input forces bit 0 of every word written while it is high to 0.
- R11: Writing a 1 to status bit 0 or bit 1 clears that flag. Writing 0 leaves it set.
- R12: A store accepted while busy with an empty buffer sets the buffer-full flag and runs after the current operation ends. A store made while the buffer is full raises `fl_wait` and is not taken until the buffer drains.
- R13: When the buffer drains into the sequencer and the interrupt enable is 1, `irq` is high for one cycle, in the first cycle that the buffer-full flag reads 0. With the enable at 0, `irq` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 6 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| fl_wr | input | 1 | CPU store to a flash word |
| fl_addr | input | 8 | Flash word address |
| fl_wdata | input | 16 | Flash store data |
| fl_wait | output | 1 | Store stalled because the buffer is full |
| dflash_err | input | 1 | Error level from the data-memory side, shown in status bit 4 |
| irq | output | 1 | Buffer-drained interrupt pulse |
| inj_stuck | input | 1 | Test hook: word bit 0 is stored as 0 |
| peek_addr | input | 8 | Array observation address |
| peek_data | output | 16 | Array word at peek_addr (0 if out of range) |

## Verification
On every cycle, the assertions check the following: that no more than one mode bit is ever set; that the locked control bits hold still while busy; that the error flags stay set unless cleared by a write of one; that the buffer is only full during an operation; that busy follows an accepted idle store; and that `irq` only comes with a drain while enabled. Other behaviours can only be shown by the bench's scenarios: the exact busy length of each operation, the stored values after programming, which words a page or block erase covers (including the information-block pairing), the verify and erase-check error paths driven through `inj_stuck`, and the ordering of buffered stores.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    typedef enum logic [1:0] {
        OPK_PROG = 2'd0,
        OPK_PAGE = 2'd1,
        OPK_MOD  = 2'd2
    } opk_e;

    // Control register image, bit 5 down to bit 0
    typedef struct packed {
        logic mod_ers;
        logic page_ers;
        logic prog_en;
        logic irq_en;
        logic no_verify;
        logic cpu_lock;
    } ctrl_t;

endpackage

// File: rtl/flash_pe_array.sv
module flash_pe_array
    import flash_pe_pkg::*;
#(
    parameter int DW          = 16,
    parameter int MAIN_WORDS  = 64,
    parameter int MAIN_BLOCKS = 2,
    parameter int INFO_WORDS  = 8,
    parameter int PAGE_WORDS  = 8,
    parameter int AW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  opk_e          wr_kind,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          stuck,
    input  logic [AW-1:0] old_addr,
    output logic [DW-1:0] old_data,
    input  opk_e          chk_kind,
    input  logic [AW-1:0] chk_addr,
    output logic [DW-1:0] chk_data,
    output logic          erased_ok,
    input  logic [AW-1:0] peek_addr,
    output logic [DW-1:0] peek_data
);
    localparam int INFO_BASE = MAIN_BLOCKS * MAIN_WORDS;
    localparam int WORDS     = INFO_BASE + INFO_WORDS;

    logic [DW-1:0] mem_q [WORDS];
    logic [DW-1:0] mem_d [WORDS];
    logic [DW-1:0] keep_mask;

    function automatic int blk_of(input int a);
        return (a >= INFO_BASE) ? MAIN_BLOCKS : a / MAIN_WORDS;
    endfunction

    function automatic logic covers(input int i, input opk_e k, input int a);
        if (k == OPK_PAGE)
            return (i / PAGE_WORDS) == (a / PAGE_WORDS);
        if (k == OPK_MOD)
            return (blk_of(i) == blk_of(a)) ||
                   ((blk_of(a) == MAIN_BLOCKS) && (blk_of(i) == 0));
        return 1'b0;
    endfunction

    function automatic logic [DW-1:0] rd(input logic [AW-1:0] a);
        return (int'(a) < WORDS) ? mem_q[a] : '0;
    endfunction

    assign keep_mask = stuck ? ~DW'(1) : '1;

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            mem_d[i] = mem_q[i];
            if (wr_en) begin
                if (wr_kind == OPK_PROG) begin
                    if (i == int'(wr_addr))
                        mem_d[i] = mem_q[i] & wr_data & keep_mask;
                end else if (covers(i, wr_kind, int'(wr_addr))) begin
                    mem_d[i] = keep_mask;
                end
            end
        end
    end

    always_comb begin
        erased_ok = 1'b1;
        for (int i = 0; i < WORDS; i++) begin
            if (covers(i, chk_kind, int'(chk_addr)) && (mem_q[i] != '1))
                erased_ok = 1'b0;
        end
    end

    assign old_data  = rd(old_addr);
    assign chk_data  = rd(chk_addr);
    assign peek_data = rd(peek_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
        end else begin
            for (int i = 0; i < WORDS; i++) mem_q[i] <= mem_d[i];
        end
    end

endmodule

// File: rtl/flash_pe_seq.sv
module flash_pe_seq
    import flash_pe_pkg::*;
#(
    parameter int DW       = 16,
    parameter int AW       = 8,
    parameter int WORDS    = 136,
    parameter int PROG_CYC = 8,
    parameter int PAGE_CYC = 32,
    parameter int MOD_CYC  = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fl_wr,
    input  logic [AW-1:0] fl_addr,
    input  logic [DW-1:0] fl_wdata,
    input  ctrl_t         ctrl,
    input  logic [DW-1:0] old_data_i,
    input  logic [DW-1:0] chk_data_i,
    input  logic          erased_ok_i,
    output logic          busy_o,
    output logic          full_o,
    output logic          wait_o,
    output logic          drain_o,
    output logic          wr_en_o,
    output opk_e          wr_kind_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [DW-1:0] wr_data_o,
    output opk_e          chk_kind_o,
    output logic [AW-1:0] chk_addr_o,
    output logic          perr_set_o,
    output logic          eerr_set_o
);
    localparam int MAX_A = (PROG_CYC > PAGE_CYC) ? PROG_CYC : PAGE_CYC;
    localparam int MAXC  = (MAX_A > MOD_CYC) ? MAX_A : MOD_CYC;
    localparam int CW    = (MAXC > 1) ? $clog2(MAXC) : 1;

    typedef struct packed {
        logic          busy;
        logic          full;
        logic [CW-1:0] cnt;
        opk_e          cur_kind;
        logic [AW-1:0] cur_addr;
        logic [DW-1:0] expect_w;
        opk_e          buf_kind;
        logic [AW-1:0] buf_addr;
        logic [DW-1:0] buf_data;
    } seq_st_t;

    seq_st_t s_q, s_d;

    logic          mode_any, in_range, accept, finish, start;
    opk_e          kind_in, st_kind;
    logic [AW-1:0] st_addr;
    logic [DW-1:0] st_data;

    function automatic logic [CW-1:0] last_cnt(input opk_e k);
        case (k)
            OPK_PROG: return CW'(PROG_CYC - 1);
            OPK_PAGE: return CW'(PAGE_CYC - 1);
            default:  return CW'(MOD_CYC - 1);
        endcase
    endfunction

    assign mode_any = ctrl.prog_en | ctrl.page_ers | ctrl.mod_ers;
    assign kind_in  = ctrl.prog_en ? OPK_PROG : (ctrl.page_ers ? OPK_PAGE : OPK_MOD);
    assign in_range = int'(fl_addr) < WORDS;
    assign accept   = fl_wr & ~ctrl.cpu_lock & mode_any & in_range & ~s_q.full;
    assign finish   = s_q.busy & (s_q.cnt == '0);

    always_comb begin
        s_d     = s_q;
        start   = 1'b0;
        st_kind = kind_in;
        st_addr = fl_addr;
        st_data = fl_wdata;

        if (s_q.busy && !finish)
            s_d.cnt = s_q.cnt - 1'b1;

        if (finish) begin
            if (s_q.full) begin
                start     = 1'b1;
                st_kind   = s_q.buf_kind;
                st_addr   = s_q.buf_addr;
                st_data   = s_q.buf_data;
                s_d.full  = 1'b0;
            end else if (accept) begin
                start = 1'b1;
            end else begin
                s_d.busy = 1'b0;
            end
        end else if (accept) begin
            if (!s_q.busy) begin
                start = 1'b1;
            end else begin
                s_d.full     = 1'b1;
                s_d.buf_kind = kind_in;
                s_d.buf_addr = fl_addr;
                s_d.buf_data = fl_wdata;
            end
        end

        if (start) begin
            s_d.busy     = 1'b1;
            s_d.cnt      = last_cnt(st_kind);
            s_d.cur_kind = st_kind;
            s_d.cur_addr = st_addr;
            s_d.expect_w = old_data_i & st_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{busy: 1'b0, full: 1'b0, cnt: '0, cur_kind: OPK_PROG,
                     cur_addr: '0, expect_w: '0, buf_kind: OPK_PROG,
                     buf_addr: '0, buf_data: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o     = s_q.busy;
    assign full_o     = s_q.full;
    assign wait_o     = fl_wr & s_q.full;
    assign drain_o    = finish & s_q.full;
    assign wr_en_o    = start;
    assign wr_kind_o  = st_kind;
    assign wr_addr_o  = st_addr;
    assign wr_data_o  = st_data;
    assign chk_kind_o = s_q.cur_kind;
    assign chk_addr_o = s_q.cur_addr;
    assign perr_set_o = finish & (s_q.cur_kind == OPK_PROG) & ~ctrl.no_verify &
                        (chk_data_i != s_q.expect_w);
    assign eerr_set_o = finish & (s_q.cur_kind != OPK_PROG) & ~erased_ok_i;

    // R12: the buffer only holds a word behind a running operation
    assert_full_needs_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.full |-> s_q.busy);

    // R5: a store taken while idle makes busy rise at the next edge
    assert_busy_after_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !s_q.busy) |=> s_q.busy);

    // R6: a locked-out store never starts an operation from idle
    assert_lock_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_wr && ctrl.cpu_lock && !s_q.busy) |=> !s_q.busy);

endmodule

// File: rtl/flash_pe_regs.sv
module flash_pe_regs
    import flash_pe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_sel,
    input  logic [5:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       busy_i,
    input  logic       full_i,
    input  logic       drain_i,
    input  logic       perr_set_i,
    input  logic       eerr_set_i,
    input  logic       dflash_err,
    output ctrl_t      ctrl_o,
    output logic       irq_o
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  eerr;
        logic  perr;
        logic  irq;
    } reg_st_t;

    reg_st_t r_q, r_d;
    ctrl_t   wc;

    assign wc = ctrl_t'(reg_wdata);

    always_comb begin
        r_d     = r_q;
        r_d.irq = drain_i & r_q.ctrl.irq_en;

        if (reg_wr && !reg_sel) begin
            r_d.ctrl.irq_en = wc.irq_en;
            if (!busy_i) begin
                r_d.ctrl.cpu_lock  = wc.cpu_lock;
                r_d.ctrl.no_verify = wc.no_verify;
                if ($countones({wc.prog_en, wc.page_ers, wc.mod_ers}) <= 1) begin
                    r_d.ctrl.prog_en  = wc.prog_en;
                    r_d.ctrl.page_ers = wc.page_ers;
                    r_d.ctrl.mod_ers  = wc.mod_ers;
                end
            end
        end

        if (reg_wr && reg_sel) begin
            if (reg_wdata[0]) r_d.eerr = 1'b0;
            if (reg_wdata[1]) r_d.perr = 1'b0;
        end
        if (eerr_set_i) r_d.eerr = 1'b1;
        if (perr_set_i) r_d.perr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ctrl_o    = r_q.ctrl;
    assign irq_o     = r_q.irq;
    assign reg_rdata = reg_sel ? {3'b000, dflash_err, full_i, busy_i, r_q.perr, r_q.eerr}
                               : {2'b00, r_q.ctrl};

    assert_modes_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({r_q.ctrl.prog_en, r_q.ctrl.page_ers, r_q.ctrl.mod_ers}));

    assert_locked_while_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable({r_q.ctrl.cpu_lock, r_q.ctrl.no_verify, r_q.ctrl.prog_en,
                            r_q.ctrl.page_ers, r_q.ctrl.mod_ers}));

    assert_eerr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.eerr && !(reg_wr && reg_sel && reg_wdata[0])) |=> r_q.eerr);

    assert_perr_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.perr && !(reg_wr && reg_sel && reg_wdata[1])) |=> r_q.perr);

    assert_irq_on_drain_R13: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($fell(full_i) && $past(r_q.ctrl.irq_en)));

endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
    import flash_pe_pkg::*;
#(
    parameter int DW          = 16,
    parameter int MAIN_WORDS  = 64,
    parameter int MAIN_BLOCKS = 2,
    parameter int INFO_WORDS  = 8,
    parameter int PAGE_WORDS  = 8,
    parameter int PROG_CYC    = 8,
    parameter int PAGE_CYC    = 32,
    parameter int MOD_CYC     = 128,
    localparam int WORDS      = MAIN_BLOCKS * MAIN_WORDS + INFO_WORDS,
    localparam int AW         = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [5:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    input  logic          fl_wr,
    input  logic [AW-1:0] fl_addr,
    input  logic [DW-1:0] fl_wdata,
    output logic          fl_wait,
    input  logic          dflash_err,
    output logic          irq,
    input  logic          inj_stuck,
    input  logic [AW-1:0] peek_addr,
    output logic [DW-1:0] peek_data
);
    ctrl_t         ctrl;
    logic          busy, full, drain, wr_en, perr_set, eerr_set, erased_ok;
    opk_e          wr_kind, chk_kind;
    logic [AW-1:0] wr_addr, chk_addr;
    logic [DW-1:0] wr_data, old_data, chk_data;

    flash_pe_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy_i     (busy),
        .full_i     (full),
        .drain_i    (drain),
        .perr_set_i (perr_set),
        .eerr_set_i (eerr_set),
        .dflash_err (dflash_err),
        .ctrl_o     (ctrl),
        .irq_o      (irq)
    );

    flash_pe_seq #(
        .DW(DW), .AW(AW), .WORDS(WORDS),
        .PROG_CYC(PROG_CYC), .PAGE_CYC(PAGE_CYC), .MOD_CYC(MOD_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .fl_wr       (fl_wr),
        .fl_addr     (fl_addr),
        .fl_wdata    (fl_wdata),
        .ctrl        (ctrl),
        .old_data_i  (old_data),
        .chk_data_i  (chk_data),
        .erased_ok_i (erased_ok),
        .busy_o      (busy),
        .full_o      (full),
        .wait_o      (fl_wait),
        .drain_o     (drain),
        .wr_en_o     (wr_en),
        .wr_kind_o   (wr_kind),
        .wr_addr_o   (wr_addr),
        .wr_data_o   (wr_data),
        .chk_kind_o  (chk_kind),
        .chk_addr_o  (chk_addr),
        .perr_set_o  (perr_set),
        .eerr_set_o  (eerr_set)
    );

    flash_pe_array #(
        .DW(DW), .MAIN_WORDS(MAIN_WORDS), .MAIN_BLOCKS(MAIN_BLOCKS),
        .INFO_WORDS(INFO_WORDS), .PAGE_WORDS(PAGE_WORDS), .AW(AW)
    ) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_kind   (wr_kind),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .stuck     (inj_stuck),
        .old_addr  (wr_addr),
        .old_data  (old_data),
        .chk_kind  (chk_kind),
        .chk_addr  (chk_addr),
        .chk_data  (chk_data),
        .erased_ok (erased_ok),
        .peek_addr (peek_addr),
        .peek_data (peek_data)
    );

endmodule

// File: tb/flash_pe_ctrl_test.sv
module flash_pe_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 136;

    localparam logic [5:0] C_NONE = 6'b000000;
    localparam logic [5:0] C_PROG = 6'b001000;
    localparam logic [5:0] C_PAGE = 6'b010000;
    localparam logic [5:0] C_MOD  = 6'b100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_sel = 1'b0;
    logic [5:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        fl_wr = 1'b0;
    logic [7:0]  fl_addr = '0;
    logic [15:0] fl_wdata = '0;
    logic        fl_wait, irq;
    logic        dflash_err = 1'b0, inj_stuck = 1'b0;
    logic [7:0]  peek_addr = '0;
    logic [15:0] peek_data;

    int vectors = 0, miscompares = 0, cycles = 0, irq_seen = 0;
    logic [15:0] model [NW];

    flash_pe_ctrl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fl_wr(fl_wr),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_wait(fl_wait),
        .dflash_err(dflash_err), .irq(irq), .inj_stuck(inj_stuck),
        .peek_addr(peek_addr), .peek_data(peek_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rst_n && irq) irq_seen++;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog (all): actual %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // expected-value functions
    function automatic int blk(input int a);
        return (a >= 128) ? 2 : a / 64;
    endfunction
    function automatic logic in_page(input int i, input int a);
        return (i / 8) == (a / 8);
    endfunction
    function automatic logic in_mod(input int i, input int a);
        return blk(i) == blk(a) || (blk(a) == 2 && blk(i) == 0);
    endfunction
    function automatic logic [15:0] mask_of(input logic st);
        return st ? 16'hFFFE : 16'hFFFF;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic sel, input logic [5:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0; #1;
    endtask

    task automatic rreg(input logic sel, output logic [7:0] v);
        reg_sel = sel; #1; v = reg_rdata;
    endtask

    task automatic peek(input int a, output logic [15:0] v);
        peek_addr = 8'(a); #1; v = peek_data;
    endtask

    task automatic fwrite(input int a, input logic [15:0] d);
        fl_wr = 1'b1; fl_addr = 8'(a); fl_wdata = d; #1;
        while (fl_wait) begin @(negedge clk); #1; end
        @(posedge clk); @(negedge clk);
        fl_wr = 1'b0; #1;
    endtask

    task automatic busy_len(output int n);
        logic [7:0] s;
        n = 0;
        rreg(1'b1, s);
        while (s[2]) begin n++; @(negedge clk); #1; rreg(1'b1, s); end
    endtask

    task automatic m_prog(input int a, input logic [15:0] d);
        model[a] = model[a] & d & mask_of(inj_stuck);
    endtask
    task automatic m_erase(input logic is_mod, input int a);
        for (int i = 0; i < NW; i++)
            if (is_mod ? in_mod(i, a) : in_page(i, a)) model[i] = mask_of(inj_stuck);
    endtask

    task automatic cmp_all(input string tag);
        logic [15:0] v;
        int bad = 0;
        for (int i = 0; i < NW; i++) begin
            peek(i, v);
            if (v !== model[i]) begin
                if (bad == 0) chk(tag, {16'(i), v}, {16'(i), model[i]});
                bad++;
            end
        end
        if (bad == 0) chk(tag, 0, 0);
    endtask

    initial begin
        logic [7:0] s;
        logic [15:0] v;
        int n;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1; #1;

        // R1 reset state
        rreg(1'b0, s); chk("R1 ctrl", s, 0);
        rreg(1'b1, s); chk("R1 status", s, 0);
        chk("R1 irq", irq, 0);
        cmp_all("R1 array erased");

        // R2 layout
        dflash_err = 1'b1; rreg(1'b1, s); chk("R2 status bit4", s, 8'h10);
        dflash_err = 1'b0;
        wreg(1'b0, C_PROG); rreg(1'b0, s); chk("R2 ctrl readback", s, 8'h08);

        // R3 mode exclusivity
        wreg(1'b0, 6'b011100); rreg(1'b0, s); chk("R3 multi-mode rejected", s, 8'h0C);
        wreg(1'b0, C_PROG);

        // R5 programming and busy length
        fwrite(5, 16'hA5F0); m_prog(5, 16'hA5F0);
        busy_len(n); chk("R5 prog busy cycles", n, 8);
        peek(5, v); chk("R5 word", v, model[5]);
        fwrite(5, 16'h0FFF); m_prog(5, 16'h0FFF);
        busy_len(n); peek(5, v); chk("R5 AND rule", v, 16'h05F0);

        // R4 lock while busy
        fwrite(6, 16'h1234); m_prog(6, 16'h1234);
        wreg(1'b0, 6'b010110); rreg(1'b0, s); chk("R4 locked bits", s, 8'h0C);
        busy_len(n); wreg(1'b0, C_PROG);

        // R6 ignored stores
        wreg(1'b0, 6'b001001); fwrite(10, 16'h0000);
        rreg(1'b1, s); chk("R6 lockout no busy", s[2], 0);
        wreg(1'b0, C_NONE); fwrite(11, 16'h0000);
        rreg(1'b1, s); chk("R6 no mode no busy", s[2], 0);
        wreg(1'b0, C_PROG); fwrite(200, 16'h0000);
        rreg(1'b1, s); chk("R6 out of range no busy", s[2], 0);
        cmp_all("R6 array untouched");

        // R7 page erase
        foreach (model[i]) ;
        for (int a = 15; a <= 24; a += 3) begin fwrite(a, 16'h0000); m_prog(a, 0); busy_len(n); end
        fwrite(24, 16'h0000); m_prog(24, 0); busy_len(n);
        wreg(1'b0, C_PAGE);
        fwrite(19, 16'h0000); m_erase(1'b0, 19);
        busy_len(n); chk("R7 page busy cycles", n, 32);
        cmp_all("R7 page range");

        // R8 block erase, main then information
        wreg(1'b0, C_PROG);
        fwrite(70, 0); m_prog(70, 0); busy_len(n);
        fwrite(100, 0); m_prog(100, 0); busy_len(n);
        fwrite(3, 0); m_prog(3, 0); busy_len(n);
        fwrite(130, 0); m_prog(130, 0); busy_len(n);
        wreg(1'b0, C_MOD);
        fwrite(65, 16'h0); m_erase(1'b1, 65);
        busy_len(n); chk("R8 block busy cycles", n, 128);
        cmp_all("R8 main block erase");
        wreg(1'b0, C_PROG);
        fwrite(100, 0); m_prog(100, 0); busy_len(n);
        wreg(1'b0, C_MOD);
        fwrite(131, 16'h0); m_erase(1'b1, 131); busy_len(n);
        peek(3, v); chk("R8 info pairs main0", v, 16'hFFFF);
        peek(100, v); chk("R8 block1 kept", v, 16'h0000);
        cmp_all("R8 info erase");

        // R9 verify with stuck bit
        wreg(1'b0, C_PROG);
        inj_stuck = 1'b1;
        fwrite(40, 16'h0001); m_prog(40, 16'h0001); busy_len(n);
        rreg(1'b1, s); chk("R9 program error set", s[1], 1);
        // R11 write-one-to-clear
        wreg(1'b1, 6'b000000); rreg(1'b1, s); chk("R11 zero keeps perr", s[1], 1);
        wreg(1'b1, 6'b000010); rreg(1'b1, s); chk("R11 one clears perr", s[1], 0);
        wreg(1'b0, 6'b001010);
        fwrite(41, 16'h0003); m_prog(41, 16'h0003); busy_len(n);
        rreg(1'b1, s); chk("R9 verify off no error", s[1], 0);
        peek(41, v); chk("R9 stored stuck", v, 16'h0002);

        // R10 erase check
        wreg(1'b0, C_PAGE);
        fwrite(40, 0); m_erase(1'b0, 40); busy_len(n);
        rreg(1'b1, s); chk("R10 erase error set", s[0], 1);
        peek(40, v); chk("R10 stuck erased word", v, 16'hFFFE);
        wreg(1'b1, 6'b000010); rreg(1'b1, s); chk("R11 wrong bit keeps eerr", s[0], 1);
        wreg(1'b1, 6'b000001); rreg(1'b1, s); chk("R11 one clears eerr", s[0], 0);
        inj_stuck = 1'b0;
        fwrite(40, 0); m_erase(1'b0, 40); busy_len(n);
        rreg(1'b1, s); chk("R10 clean erase no error", s[0], 0);

        // R12 / R13 buffer, wait and interrupt
        wreg(1'b0, 6'b001100);
        irq_seen = 0;
        fwrite(50, 16'h00FF); m_prog(50, 16'h00FF);
        fwrite(51, 16'h0F0F); m_prog(51, 16'h0F0F);
        rreg(1'b1, s); chk("R12 buffer full", s[3:2], 2'b11);
        fl_wr = 1'b1; fl_addr = 8'd52; fl_wdata = 16'h3333; #1;
        chk("R12 wait while full", fl_wait, 1);
        fwrite(52, 16'h3333); m_prog(52, 16'h3333);
        busy_len(n);
        chk("R13 irq per drain", irq_seen, 2);
        cmp_all("R12 buffered data");
        wreg(1'b0, C_PROG);
        irq_seen = 0;
        fwrite(53, 16'h1111); m_prog(53, 16'h1111);
        fwrite(54, 16'h2222); m_prog(54, 16'h2222);
        busy_len(n);
        chk("R13 no irq when disabled", irq_seen, 0);

        // random programming mixed with page erases
        for (int k = 0; k < 60; k++) begin
            int a;
            logic [15:0] d;
            a = int'($urandom % NW);
            d = 16'($urandom);
            if ($urandom % 8 == 0) begin
                wreg(1'b0, C_PAGE);
                fwrite(a, d); m_erase(1'b0, a); busy_len(n);
                wreg(1'b0, C_PROG);
            end else begin
                fwrite(a, d); m_prog(a, d); busy_len(n);
            end
            peek(a, v); chk("R5 random word", v, model[a]);
        end
        rreg(1'b1, s); chk("R9 random no errors", s[1:0], 0);
        cmp_all("R7 random array");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule